// File: doc/BRIEF.md
# Sequential Integer Divider with Selectable Rounding

This block divides a dividend by a divisor over several clock cycles and returns both a quotient and a remainder. A single pulse on `start` captures the operands and the rounding selection. The block then runs one restoring iteration per result bit on the operand magnitudes, applies the signs, and raises `done` for one cycle with the results valid.

The `floor_mode` input picks the rounding at run time. When it is low, the result follows the ordinary hardware-language divide and modulo operators: the quotient rounds toward zero. When it is high, the quotient rounds toward minus infinity and the remainder follows the divisor's sign. The flooring result is derived from the truncating one. When the remainder is non-zero and its sign disagrees with the divisor's sign, the quotient is lowered by one and the divisor is added to the remainder.

Each operand has its own width and its own signedness parameter. Both results are one bit wider than the wider operand, so every quotient, including the most-negative-over-minus-one case, is exact. A zero divisor yields a defined result instead of an error.

Top module: `int_divider`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `done`, `quotient` and `remainder` are all zero until the first division completes.
- R2: With `floor_mode` low and a non-zero divisor, the quotient is the exact quotient rounded toward zero. The remainder equals dividend minus quotient times divisor, so it is zero or carries the dividend's sign.
- R3: With `floor_mode` high and a non-zero divisor, the quotient is the exact quotient rounded toward minus infinity. The remainder is zero or carries the divisor's sign. For example, -10/3 gives quotient -4 and remainder 2, and 10/-3 gives quotient -4 and remainder -2.
- R4: When the dividend and divisor have the same sign, both modes give identical results. For example, 10/3 gives quotient 3 and remainder 1, and -10/-3 gives quotient 3 and remainder -1. In truncating mode, -10/3 gives quotient -3 and remainder -1, and 10/-3 gives quotient -3 and remainder 1.
- R5: An operand whose signedness parameter is non-zero is sign-extended to the result width. An operand whose signedness parameter is zero is zero-extended. With both parameters zero, the bit pattern 8'hF6 is read as 246.
- R6: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle on. `done` is high for exactly one cycle, starting EW+1 clock edges after the accepted start, where EW is the wider operand width plus one. `busy` is low while `done` is high.
- R7: A `start` pulse or operand change while `busy` is high has no effect. The running division completes with the operands captured at acceptance, and no extra `done` follows.
- R8: A zero divisor, in either mode, gives a quotient of all ones and a remainder equal to the extended dividend.
- R9: `quotient` and `remainder` change only in the cycle where `done` is high and hold their values otherwise.
- R10: The most negative signed dividend divided by -1 gives the exact positive quotient, for example -128/-1 = 128 in the 9-bit result, with remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse; accepted only when idle |
| floor_mode | input | 1 | 0 = truncating, 1 = flooring |
| dividend | input | A_W | Dividend operand |
| divisor | input | B_W | Divisor operand |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse; results valid |
| quotient | output | EW | Signed quotient, EW = max(A_W,B_W)+1 |
| remainder | output | EW | Signed remainder |

## Verification
A start accepted at a clock edge produces `done` and new results EW+1 edges later: 10 edges with the default 8-bit operands. This latency does not depend on the operand values, the mode or a zero divisor. The bench drives on falling edges and counts falling edges after the start edge. It requires `done` to appear at exactly the tenth, and it compares the quotient and remainder in that same sample. In the disturbed runs, it watches twelve further samples to confirm that no further `done` appears. In the hold checks, it samples several cycles after `done` to confirm the outputs have not moved.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int A_SIGNED = 1,
  parameter int B_SIGNED = 1,
  localparam int EW = ((A_W > B_W) ? A_W : B_W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          floor_mode,
  input  logic [A_W-1:0] dividend,
  input  logic [B_W-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [EW-1:0] quotient,
  output logic [EW-1:0] remainder
);
  localparam int CW = $clog2(EW + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;

  logic [CW-1:0] cnt;
  logic [EW-1:0] rem, qr, mb_q, ax_q, bx_q;
  logic          sa_q, sb_q, fm_q;

  logic          a_neg, b_neg;
  logic [EW-1:0] ax, bx, ma, mb;
  assign a_neg = (A_SIGNED != 0) && dividend[A_W-1];
  assign b_neg = (B_SIGNED != 0) && divisor[B_W-1];
  assign ax = {{(EW-A_W){a_neg}}, dividend};
  assign bx = {{(EW-B_W){b_neg}}, divisor};
  assign ma = a_neg ? -ax : ax;
  assign mb = b_neg ? -bx : bx;

  logic [EW:0] rw, diff;
  assign rw   = {rem, qr[EW-1]};
  assign diff = rw - {1'b0, mb_q};

  logic [EW-1:0] tq, tr, fq, fr;
  logic          adj, bz;
  assign bz  = (bx_q == '0);
  assign tq  = (sa_q ^ sb_q) ? -qr : qr;
  assign tr  = sa_q ? -rem : rem;
  assign adj = fm_q && (rem != '0) && (sa_q != sb_q);
  assign fq  = bz ? '1 : (adj ? tq - 1'b1 : tq);
  assign fr  = bz ? ax_q : (adj ? tr + bx_q : tr);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      rem       <= '0;
      qr        <= '0;
      mb_q      <= '0;
      ax_q      <= '0;
      bx_q      <= '0;
      sa_q      <= 1'b0;
      sb_q      <= 1'b0;
      fm_q      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          cnt   <= CW'(EW);
          rem   <= '0;
          qr    <= ma;
          mb_q  <= mb;
          ax_q  <= ax;
          bx_q  <= bx;
          sa_q  <= a_neg;
          sb_q  <= b_neg;
          fm_q  <= floor_mode;
        end
        S_RUN: begin
          if (!diff[EW]) begin
            rem <= diff[EW-1:0];
            qr  <= {qr[EW-2:0], 1'b1};
          end else begin
            rem <= rw[EW-1:0];
            qr  <= {qr[EW-2:0], 1'b0};
          end
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= S_FIN;
        end
        S_FIN: begin
          quotient  <= fq;
          remainder <= fr;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int EW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [EW-1:0] quotient,
  input logic [EW-1:0] remainder,
  input logic          sa_q,
  input logic          sb_q,
  input logic          fm_q,
  input logic [EW-1:0] bx_q
);
  p_trunc_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fm_q && bx_q != '0 && remainder != '0) |-> (remainder[EW-1] == sa_q));

  p_floor_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fm_q && bx_q != '0 && remainder != '0) |-> (remainder[EW-1] == sb_q));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind int_divider int_divider_chk #(.EW(EW)) u_chk (.*);

// File: tb/sim_int_divider.sv
`timescale 1ns/1ps
module sim_int_divider;
  localparam int AW = 8;
  localparam int BW = 8;
  localparam int EWB = AW + 1;
  localparam int LAT = EWB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic floor_mode = 1'b0;
  logic [AW-1:0] dividend = '0;
  logic [BW-1:0] divisor = '0;
  logic b0, d0, b1, d1;
  logic [EWB-1:0] q0, r0, q1, r1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  int_divider #(.A_W(AW), .B_W(BW), .A_SIGNED(1), .B_SIGNED(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
    .dividend(dividend), .divisor(divisor), .busy(b0), .done(d0),
    .quotient(q0), .remainder(r0));

  int_divider #(.A_W(AW), .B_W(BW), .A_SIGNED(0), .B_SIGNED(0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .floor_mode(floor_mode),
    .dividend(dividend), .divisor(divisor), .busy(b1), .done(d1),
    .quotient(q1), .remainder(r1));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2*EWB-1:0] model(input logic [AW-1:0] a, input logic [BW-1:0] b,
                                             input bit sgn, input bit fl);
    longint av, bv, q, r;
    av = sgn ? longint'($signed(a)) : longint'(a);
    bv = sgn ? longint'($signed(b)) : longint'(b);
    if (bv == 0) begin
      q = -1;
      r = av;
    end else begin
      q = av / bv;
      r = av % bv;
      if (fl && r != 0 && ((r < 0) != (bv < 0))) begin
        q = q - 1;
        r = r + bv;
      end
    end
    return {q[EWB-1:0], r[EWB-1:0]};
  endfunction

  task automatic run(input logic [AW-1:0] a, input logic [BW-1:0] b, input bit fl,
                     input bit disturb, input string req, input string req_u);
    logic [2*EWB-1:0] e0, e1;
    int j;
    int extra;
    e0 = model(a, b, 1'b1, fl);
    e1 = model(a, b, 1'b0, fl);
    @(negedge clk);
    dividend = a; divisor = b; floor_mode = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = ~a; divisor = b + 8'd1; floor_mode = ~fl;
    j = 0;
    while (!d0 && j < 40) begin
      @(negedge clk);
      j++;
      start = 1'b0;
      if (disturb && j == 3) begin
        start = 1'b1;
        dividend = AW'($urandom);
        divisor = BW'($urandom);
      end
    end
    chk(j == LAT, "R6", "done latency", j, LAT);
    chk(d1 == 1'b1, "R6", "u1 done aligned", d1, 1);
    chk(b0 == 1'b0, "R6", "busy low at done", b0, 0);
    chk(q0 == e0[2*EWB-1:EWB], req, "quotient", $signed(q0), $signed(e0[2*EWB-1:EWB]));
    chk(r0 == e0[EWB-1:0], req, "remainder", $signed(r0), $signed(e0[EWB-1:0]));
    chk(q1 == e1[2*EWB-1:EWB], req_u, "unsigned quotient", $signed(q1), $signed(e1[2*EWB-1:EWB]));
    chk(r1 == e1[EWB-1:0], req_u, "unsigned remainder", $signed(r1), $signed(e1[EWB-1:0]));
    if (disturb) begin
      extra = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (d0) extra++;
      end
      chk(extra == 0, "R7", "no extra done", extra, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [EWB-1:0] hq, hr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(b0 == 0 && d0 == 0, "R1", "busy/done in reset", {b0, d0}, 0);
    chk(q0 == 0 && r0 == 0, "R1", "outputs in reset", {q0, r0}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(b0 == 0 && d0 == 0 && q0 == 0 && r0 == 0, "R1", "idle after reset", {b0, d0, q0, r0}, 0);

    run(8'hF6, 8'd3, 1'b0, 1'b0, "R4", "R5");
    run(8'hF6, 8'd3, 1'b1, 1'b0, "R3", "R5");
    run(8'd10, 8'hFD, 1'b0, 1'b0, "R4", "R5");
    run(8'd10, 8'hFD, 1'b1, 1'b0, "R3", "R5");
    run(8'd10, 8'd3, 1'b1, 1'b0, "R4", "R5");
    run(8'hF6, 8'hFD, 1'b1, 1'b0, "R4", "R5");
    run(8'hF6, 8'hFD, 1'b0, 1'b0, "R4", "R5");
    run(8'h80, 8'hFF, 1'b0, 1'b0, "R10", "R5");
    run(8'h80, 8'hFF, 1'b1, 1'b0, "R10", "R5");
    run(8'h7F, 8'h80, 1'b1, 1'b0, "R3", "R5");
    run(8'hF6, 8'd0, 1'b0, 1'b0, "R8", "R8");
    run(8'd37, 8'd0, 1'b1, 1'b0, "R8", "R8");
    run(8'd0, 8'hF9, 1'b1, 1'b0, "R3", "R5");
    run(8'hF6, 8'd3, 1'b1, 1'b1, "R3", "R7");
    run(8'd100, 8'hF9, 1'b0, 1'b1, "R2", "R7");

    hq = q0; hr = r0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      dividend = AW'($urandom);
      divisor = BW'($urandom);
      floor_mode = ~floor_mode;
    end
    chk(q0 == hq && r0 == hr, "R9", "outputs hold while idle", {q0, r0}, {hq, hr});

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [BW-1:0] b;
      bit fl;
      a = AW'($urandom);
      b = ($urandom % 8 == 0) ? '0 : BW'($urandom);
      fl = 1'($urandom);
      run(a, b, fl, (i % 25 == 0), (b == 0) ? "R8" : (fl ? "R3" : "R2"), "R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule